// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Programmable Level Flags

This block buffers words between a writer and a reader that run on unrelated clocks. The storage holds `2**AW` words. Write and read pointers cross between the two clock domains as Gray code through two-flop synchronisers. All level flags come from these synchronised pointers. A flag may therefore assert early or release late while traffic is in flight, but it never allows an overflow or an underflow.

A mode input is captured while reset is held, together with an almost-empty offset `n` and an almost-full offset `m`. The captured values hold until the next reset.

In standard mode:
- every word, the first included, leaves only on an explicit read request;
- `rd_flag` acts as an active-low empty flag;
- `wr_flag` acts as an active-low full flag.

In fall-through mode:
- an output register pre-loads the oldest word without any request;
- `rd_flag` acts as an active-low output-ready flag;
- `wr_flag` acts as an active-high not-ready flag.

Because the output register counts as storage in fall-through mode, the capacity grows by one word and every threshold moves up by one.

Top module: `dual_mode_fifo`

## Requirements
- R1: The mode is captured from `mode_sel` while `rst_n` is low: 0 selects standard, 1 selects fall-through. Changes on `mode_sel` after reset have no effect. Standard mode: `rd_flag`=1 means data is readable and `wr_flag`=0 means full. Fall-through mode: `rd_flag`=0 means data is readable and `wr_flag`=1 means full.
- R2: In standard mode, `rd_data` is 0 after reset and changes only on a `rd_clk` rising edge where `rd_en_n` is 0 and data is present. It then shows the oldest stored word.
- R3: In fall-through mode, a word written into an empty FIFO appears on `rd_data`, with `rd_flag` going low, on the third `rd_clk` rising edge after the write edge, with no read request. Each further word needs `rd_en_n`=0 while `rd_flag` is low.
- R4: In standard mode, with k words stored:
  - `pae_n` is 1 exactly when k > n;
  - `hf_n` is 0 exactly when k ≥ D/2+1;
  - `paf_n` is 0 exactly when k ≥ D−m;
  - the FIFO is full at k = D.
- R5: In fall-through mode, with k words stored (the output register included):
  - `pae_n` is 1 exactly when k > n+1;
  - `hf_n` is 0 exactly when k ≥ D/2+2;
  - `paf_n` is 0 exactly when k ≥ D+1−m;
  - the FIFO is full at k = D+1, which is also its capacity.
- R6: A write attempted while full is dropped: it stores nothing and leaves every flag unchanged. One read releases the full indication.
- R7: A read request while empty has no effect: it leaves `rd_data` unchanged and removes no later word.
- R8: Words leave in the order they were accepted, under concurrent traffic on both clocks.
- R9: The offsets `n` (`empty_off`) and `m` (`full_off`) are captured while reset is low. Later changes on these inputs do not move the thresholds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Master reset, active low, sampled synchronously in each domain |
| mode_sel | input | 1 | Mode select captured during reset (0 standard, 1 fall-through) |
| empty_off | input | OW | Almost-empty offset n, captured during reset |
| full_off | input | OW | Almost-full offset m, captured during reset |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | DW | Word to store |
| wr_flag | output | 1 | Full indication, polarity set by mode |
| hf_n | output | 1 | Half-full, active low |
| paf_n | output | 1 | Almost-full, active low |
| rd_en_n | input | 1 | Read request, active low |
| rd_data | output | DW | Registered output word |
| rd_flag | output | 1 | Data-available indication, polarity set by mode |
| pae_n | output | 1 | Almost-empty, active low |

## Verification
The hardest state to reach is a full FIFO while both clocks are active. In that state a write is held off by a full flag that is computed from a stale read pointer, just as a read is freeing a slot.

The stimulus reaches it by pacing the writer at about three requests in four on the faster clock and the reader at about one in two on the slower clock. The storage then saturates repeatedly, and every word leaving is checked against a reference queue.

The exact thresholds and the one-word shift of fall-through mode are checked separately. The bench fills and drains one word at a time and lets both synchronisers settle before every flag comparison. The offset and mode inputs are deliberately changed after reset to show that they were captured.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FALL = 1'b1
    } fifo_mode_e;
endpackage

// File: rtl/dmf_gsync.sv
module dmf_gsync #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    typedef struct packed {
        logic [PW-1:0] s1;
        logic [PW-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = gray_in;
        sy_d.s2 = sy_q.s1;
        if (!rst_n) sy_d = '0;
    end

    always_ff @(posedge clk) sy_q <= sy_d;

    // Gray to binary: each bit folds in every higher Gray bit
    always_comb begin
        bin_out[PW-1] = sy_q.s2[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ sy_q.s2[i];
        end
    end
endmodule

// File: rtl/dmf_wside.sv
module dmf_wside
    import dmf_pkg::*;
#(
    parameter int AW = 4,
    parameter int OW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_in,
    input  logic [OW-1:0] off_in,
    input  logic          wen_n,
    input  logic [AW:0]   rsync_bin,
    input  logic [AW:0]   csync_bin,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [AW:0]   ptr,
    output logic          full,
    output logic          flag,
    output logic          hf_n,
    output logic          paf_n
);
    localparam int          PW    = AW + 1;
    localparam logic [31:0] DEPTH = 32'(1) << AW;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic          full;
        logic          hf_n;
        logic          paf_n;
        fifo_mode_e    mode;
        logic [OW-1:0] off;
    } wst_t;

    wst_t        w_d, w_q;
    logic        fire;
    logic [31:0] cnt, used, extra;

    always_comb begin
        w_d    = w_q;
        fire   = !wen_n && !w_q.full;
        w_d.ptr  = w_q.ptr + {{(PW-1){1'b0}}, fire};
        w_d.gray = w_d.ptr ^ (w_d.ptr >> 1);
        cnt    = 32'(w_d.ptr - csync_bin);
        used   = 32'(w_d.ptr - rsync_bin);
        extra  = {31'b0, w_q.mode == MODE_FALL};
        w_d.full  = (cnt >= DEPTH + extra) || (used >= DEPTH);
        w_d.hf_n  = !(cnt >= (DEPTH >> 1) + 32'd1 + extra);
        w_d.paf_n = !(cnt + 32'(w_q.off) >= DEPTH + extra);
        if (!rst_n) begin
            w_d       = '0;
            w_d.mode  = fifo_mode_e'(mode_in);
            w_d.off   = off_in;
            w_d.hf_n  = 1'b1;
            w_d.paf_n = 1'b1;
        end
    end

    always_ff @(posedge clk) w_q <= w_d;

    assign we    = fire;
    assign waddr = w_q.ptr[AW-1:0];
    assign wgray = w_q.gray;
    assign ptr   = w_q.ptr;
    assign full  = w_q.full;
    assign flag  = (w_q.mode == MODE_FALL) ? w_q.full : ~w_q.full;
    assign hf_n  = w_q.hf_n;
    assign paf_n = w_q.paf_n;
endmodule

// File: rtl/dmf_rside.sv
module dmf_rside
    import dmf_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4,
    parameter int OW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_in,
    input  logic [OW-1:0] off_in,
    input  logic          ren_n,
    input  logic [AW:0]   wsync_bin,
    input  logic [DW-1:0] mem_rd,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [AW:0]   cgray,
    output logic [DW-1:0] dout,
    output logic          flag,
    output logic          pae_n,
    output fifo_mode_e    mode
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] ptr;    // next storage slot to leave the array
        logic [PW-1:0] cptr;   // words consumed by the reader
        logic [PW-1:0] gray;
        logic [PW-1:0] cgray;
        logic          valid;
        logic          flag;
        logic          pae_n;
        fifo_mode_e    mode;
        logic [OW-1:0] off;
        logic [DW-1:0] dout;
    } rst_t;

    rst_t        r_d, r_q;
    logic        has, take, load;
    logic [31:0] cnt, extra;

    always_comb begin
        r_d   = r_q;
        has   = (r_q.ptr != wsync_bin);
        take  = 1'b0;
        load  = 1'b0;
        extra = {31'b0, r_q.mode == MODE_FALL};
        if (r_q.mode == MODE_FALL) begin
            take      = !ren_n && r_q.valid;
            load      = has && (!r_q.valid || take);
            r_d.valid = load || (r_q.valid && !take);
        end else begin
            load      = !ren_n && has;
            r_d.valid = 1'b0;
        end
        if (load) r_d.dout = mem_rd;
        r_d.ptr   = r_q.ptr + {{(PW-1){1'b0}}, load};
        r_d.cptr  = r_d.ptr - {{(PW-1){1'b0}}, r_d.valid};
        r_d.gray  = r_d.ptr ^ (r_d.ptr >> 1);
        r_d.cgray = r_d.cptr ^ (r_d.cptr >> 1);
        r_d.flag  = (r_q.mode == MODE_FALL) ? !r_d.valid : (r_d.ptr != wsync_bin);
        cnt       = 32'(wsync_bin - r_d.cptr);
        r_d.pae_n = cnt > 32'(r_q.off) + extra;
        if (!rst_n) begin
            r_d      = '0;
            r_d.mode = fifo_mode_e'(mode_in);
            r_d.off  = off_in;
            r_d.flag = mode_in;
        end
    end

    always_ff @(posedge clk) r_q <= r_d;

    assign raddr = r_q.ptr[AW-1:0];
    assign rgray = r_q.gray;
    assign cgray = r_q.cgray;
    assign dout  = r_q.dout;
    assign flag  = r_q.flag;
    assign pae_n = r_q.pae_n;
    assign mode  = r_q.mode;
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
    import dmf_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4,
    parameter int OW = AW + 1
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic [OW-1:0] empty_off,
    input  logic [OW-1:0] full_off,
    input  logic          wr_en_n,
    input  logic [DW-1:0] wr_data,
    output logic          wr_flag,
    output logic          hf_n,
    output logic          paf_n,
    input  logic          rd_en_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag,
    output logic          pae_n
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    logic          w_we, w_full;
    logic [AW-1:0] w_addr, r_addr;
    logic [PW-1:0] w_gray, w_ptr, w_rsync, w_csync;
    logic [PW-1:0] r_gray, r_cgray, r_wsync;
    logic [DW-1:0] r_mem;
    fifo_mode_e    r_mode;

    always_ff @(posedge wr_clk) begin
        if (w_we) mem[w_addr] <= wr_data;
    end
    assign r_mem = mem[r_addr];

    dmf_wside #(.AW(AW), .OW(OW)) u_wside (
        .clk(wr_clk), .rst_n(rst_n), .mode_in(mode_sel), .off_in(full_off),
        .wen_n(wr_en_n), .rsync_bin(w_rsync), .csync_bin(w_csync),
        .we(w_we), .waddr(w_addr), .wgray(w_gray), .ptr(w_ptr), .full(w_full),
        .flag(wr_flag), .hf_n(hf_n), .paf_n(paf_n)
    );

    dmf_rside #(.DW(DW), .AW(AW), .OW(OW)) u_rside (
        .clk(rd_clk), .rst_n(rst_n), .mode_in(mode_sel), .off_in(empty_off),
        .ren_n(rd_en_n), .wsync_bin(r_wsync), .mem_rd(r_mem),
        .raddr(r_addr), .rgray(r_gray), .cgray(r_cgray), .dout(rd_data),
        .flag(rd_flag), .pae_n(pae_n), .mode(r_mode)
    );

    dmf_gsync #(.PW(PW)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(w_gray), .bin_out(r_wsync)
    );
    dmf_gsync #(.PW(PW)) u_sync_r2w (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(r_gray), .bin_out(w_rsync)
    );
    dmf_gsync #(.PW(PW)) u_sync_c2w (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(r_cgray), .bin_out(w_csync)
    );
endmodule

// File: rtl/dmf_chk.sv
module dmf_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en_n,
    input logic          rd_en_n,
    input logic          rd_flag,
    input logic [DW-1:0] rd_data,
    input logic          w_full,
    input logic [AW:0]   w_ptr,
    input logic [AW:0]   w_rsync,
    input logic          r_mode
);
    localparam int          PW    = AW + 1;
    localparam logic [AW:0] DEPTH = PW'(1) << AW;

    logic [AW:0] w_used;
    assign w_used = w_ptr - w_rsync;

    // R6: a write request while full must not move the write pointer
    assert_wr_blocked_full_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (w_full && !wr_en_n) |=> $stable(w_ptr));

    // R6: storage occupancy seen by the writer never exceeds the array size
    assert_no_overflow_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        w_used <= DEPTH);

    // R8: the write pointer only steps by one and only after a request
    assert_ptr_step_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (w_ptr != $past(w_ptr)) |-> ((w_ptr == $past(w_ptr) + PW'(1)) && $past(!wr_en_n)));

    // R7: standard-mode read while empty leaves the output untouched
    assert_rd_ignored_empty_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!r_mode && !rd_flag && !rd_en_n) |=> $stable(rd_data));

    // R2: in standard mode the output moves only on a granted read
    assert_std_read_only_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!r_mode && !$stable(rd_data)) |-> $past(!rd_en_n && rd_flag));

    // R1: the captured mode does not change outside reset
    assert_mode_hold_R1: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $stable(r_mode));
endmodule

bind dual_mode_fifo dmf_chk #(.AW(AW), .DW(DW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .rd_flag(rd_flag), .rd_data(rd_data), .w_full(w_full),
    .w_ptr(w_ptr), .w_rsync(w_rsync), .r_mode(r_mode)
);

// File: tb/sim_dual_mode_fifo.sv
module sim_dual_mode_fifo;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int OW = AW + 1;
    localparam int D  = 1 << AW;

    logic          wr_clk, rd_clk, rst_n, mode_sel;
    logic [OW-1:0] empty_off, full_off;
    logic          wr_en_n, rd_en_n;
    logic [DW-1:0] wr_data, rd_data;
    logic          wr_flag, hf_n, paf_n, rd_flag, pae_n;

    int errs = 0;
    int checks = 0;
    int cur_mode, cur_n, cur_m;
    logic [DW-1:0] model[$];

    dual_mode_fifo #(.DW(DW), .AW(AW), .OW(OW)) u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .empty_off(empty_off), .full_off(full_off), .wr_en_n(wr_en_n),
        .wr_data(wr_data), .wr_flag(wr_flag), .hf_n(hf_n), .paf_n(paf_n),
        .rd_en_n(rd_en_n), .rd_data(rd_data), .rd_flag(rd_flag), .pae_n(pae_n)
    );

    // 50 MHz write clock, unrelated read clock (posedges never coincide)
    initial begin wr_clk = 0; forever #10 wr_clk = ~wr_clk; end
    initial begin rd_clk = 0; #4; forever #17 rd_clk = ~rd_clk; end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #2000000;
        errs++; checks++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int has_data();
        return cur_mode ? int'(!rd_flag) : int'(rd_flag);
    endfunction

    function automatic int is_full();
        return cur_mode ? int'(wr_flag) : int'(!wr_flag);
    endfunction

    task automatic settle();
        repeat (6) @(posedge rd_clk);
        repeat (6) @(posedge wr_clk);
        #1;
    endtask

    task automatic do_reset(input int mode, input int n, input int m);
        rst_n = 0; wr_en_n = 1; rd_en_n = 1; wr_data = '0;
        mode_sel = mode[0]; empty_off = OW'(n); full_off = OW'(m);
        cur_mode = mode; cur_n = n; cur_m = m;
        model.delete();
        repeat (8) @(posedge wr_clk);
        @(negedge wr_clk);
        rst_n = 1;
        // R1 R9: disturb captured inputs after reset
        mode_sel = ~mode[0]; empty_off = OW'(0); full_off = OW'(D - 1);
        settle();
    endtask

    task automatic check_flags(input int k);
        string tag;
        tag = cur_mode ? "R5" : "R4";
        chk({tag, " R9 almost-empty"}, int'(pae_n), int'(k > cur_n + cur_mode));
        chk({tag, " half-full"}, int'(hf_n), int'(!(k >= D / 2 + 1 + cur_mode)));
        chk({tag, " R9 almost-full"}, int'(paf_n), int'(!(k + cur_m >= D + cur_mode)));
        chk({tag, " full indication"}, is_full(), int'(k >= D + cur_mode));
        chk({tag, " data indication"}, has_data(), int'(k > 0));
    endtask

    task automatic wr_one(input logic [DW-1:0] v);
        @(negedge wr_clk);
        wr_data = v; wr_en_n = 0;
        if (is_full() == 0) model.push_back(v);
        @(negedge wr_clk);
        wr_en_n = 1;
    endtask

    task automatic rd_one();
        logic [DW-1:0] e;
        @(negedge rd_clk);
        if (has_data() == 0 || model.size() == 0) begin
            chk("R8 data expected present", has_data(), 1);
        end else if (cur_mode == 0) begin
            e = model.pop_front();
            rd_en_n = 0;
            @(posedge rd_clk); #1;
            chk("R2 R8 word order", int'(rd_data), int'(e));
            @(negedge rd_clk);
            rd_en_n = 1;
        end else begin
            chk("R3 R8 head word", int'(rd_data), int'(model[0]));
            void'(model.pop_front());
            rd_en_n = 0;
            @(negedge rd_clk);
            rd_en_n = 1;
        end
    endtask

    task automatic run_levels();
        int cap;
        logic [DW-1:0] last;
        cap = D + cur_mode;
        for (int k = 1; k <= cap; k++) begin
            wr_one(DW'(k * 7 + cur_mode * 3));
            settle();
            check_flags(k);
        end
        if (cur_mode == 0) chk("R2 no word without request", int'(rd_data), 0);
        else chk("R3 head shown without request", int'(rd_data), int'(model[0]));
        // R6: extra write while full is dropped
        wr_one(8'hEE);
        settle();
        check_flags(cap);
        for (int k = cap - 1; k >= 0; k--) begin
            rd_one();
            settle();
            check_flags(k);
        end
        // R7: requests while empty
        last = rd_data;
        @(negedge rd_clk); rd_en_n = 0;
        repeat (4) @(negedge rd_clk);
        rd_en_n = 1;
        settle();
        chk("R7 output held while empty", int'(rd_data), int'(last));
        chk("R7 still empty", has_data(), 0);
        wr_one(8'h5A);
        settle();
        check_flags(1);
        if (cur_mode == 0) chk("R2 output waits for request", int'(rd_data), int'(last));
        else chk("R3 R7 next word falls through", int'(rd_data), 8'h5A);
        rd_one();
        settle();
        check_flags(0);
    endtask

    task automatic first_word_timing();
        int edges;
        chk("R3 starts not ready", int'(rd_flag), 1);
        @(negedge wr_clk);
        wr_data = 8'h3C; wr_en_n = 0;
        model.push_back(8'h3C);
        @(posedge wr_clk);
        #2;
        wr_en_n = 1;
        edges = 0;
        while (edges < 8) begin
            @(posedge rd_clk); #1;
            edges++;
            if (!rd_flag) break;
        end
        chk("R3 read edges to output-ready", edges, 3);
        chk("R3 first word on output", int'(rd_data), 8'h3C);
        rd_one();
        settle();
        check_flags(0);
    endtask

    task automatic stream(input int nw);
        fork
            begin : writer
                int sent;
                logic [15:0] s;
                sent = 0; s = 16'hACE1;
                while (sent < nw) begin
                    @(negedge wr_clk);
                    s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
                    if (s[1:0] != 2'b00 && is_full() == 0) begin
                        wr_data = DW'(sent * 13 + 1);
                        wr_en_n = 0;
                        model.push_back(DW'(sent * 13 + 1));
                        sent++;
                    end else begin
                        wr_en_n = 1;
                    end
                end
                @(negedge wr_clk);
                wr_en_n = 1;
            end
            begin : reader
                int got;
                bit pend;
                logic [DW-1:0] pexp;
                logic [15:0] t;
                got = 0; pend = 0; pexp = '0; t = 16'h1D2B;
                while (got < nw) begin
                    @(negedge rd_clk);
                    t = {t[14:0], t[15] ^ t[13] ^ t[12] ^ t[10]};
                    if (cur_mode == 0) begin
                        if (pend) begin
                            chk("R8 stream order", int'(rd_data), int'(pexp));
                            pend = 0;
                        end
                        if (t[0] && has_data() == 1) begin
                            if (model.size() == 0) begin
                                chk("R8 read beyond written", 0, 1);
                                rd_en_n = 1;
                            end else begin
                                pexp = model.pop_front();
                                pend = 1; rd_en_n = 0; got++;
                            end
                        end else begin
                            rd_en_n = 1;
                        end
                    end else begin
                        if (has_data() == 1) begin
                            if (model.size() == 0) begin
                                chk("R8 ready beyond written", 0, 1);
                                rd_en_n = 1;
                            end else begin
                                chk("R8 stream head", int'(rd_data), int'(model[0]));
                                if (t[0]) begin
                                    void'(model.pop_front());
                                    rd_en_n = 0; got++;
                                end else begin
                                    rd_en_n = 1;
                                end
                            end
                        end else begin
                            rd_en_n = 1;
                        end
                    end
                end
                @(negedge rd_clk);
                rd_en_n = 1;
                if (pend) chk("R8 stream order", int'(rd_data), int'(pexp));
            end
        join
        settle();
        chk("R8 drained after stream", has_data(), 0);
    endtask

    initial begin
        rst_n = 0; wr_en_n = 1; rd_en_n = 1; mode_sel = 0;
        empty_off = '0; full_off = '0; wr_data = '0;

        // standard mode
        do_reset(0, 3, 2);
        chk("R1 standard data indication low", int'(rd_flag), 0);
        chk("R1 standard full indication high", int'(wr_flag), 1);
        chk("R2 output zero after reset", int'(rd_data), 0);
        check_flags(0);
        run_levels();
        stream(60);

        // fall-through mode
        do_reset(1, 5, 4);
        chk("R1 fall-through ready indication high", int'(rd_flag), 1);
        chk("R1 fall-through full indication low", int'(wr_flag), 0);
        check_flags(0);
        first_word_timing();
        run_levels();
        stream(60);

        summary();
        $finish;
    end
endmodule